// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Entry Unit

This unit decides, once per clock, whether a hart takes a trap and which privilege level handles it. It combines the pending and enabled interrupt lines, the interrupt-enable bits it holds, the current privilege and two delegation masks. From these it picks an eligible interrupt or accepts a synchronous exception. It then routes the trap to supervisor or machine level.

On a trap it updates the cause, exception-PC and bad-address registers of the chosen level, shuffles the interrupt-enable stack, records the previous privilege and drives the handler address onto `next_pc`. It also pulses a reservation-clear strobe and a TLB-flush strobe.

A breakpoint exception raised while a debugger is attached does not trap. The unit saves the PC and jumps to a fixed debug entry address instead. A narrow write port lets the surrounding core lower the privilege (for example on a trap return) and rewrite the enable bits.

Top module: `trap_unit`

## Requirements
- R1: After reset the privilege is M (code 3), `next_pc` equals `RESET_PC`, all enable bits `ie` are 0, and `trap_taken`, `dbg_enter`, `tlb_flush` and `resv_clear` are 0.
- R2: An enabled and pending interrupt whose `int_deleg` bit is 0 is taken whenever the privilege is below M. In M it is taken only when `ie[2]` (machine enable) is 1.
- R3: An interrupt whose `int_deleg` bit is 1 is taken in U (code 0) always, in S (code 1) only when `ie[1]` (supervisor enable) is 1, and never in M.
- R4: Among eligible interrupts the lowest index wins, and the cause is that index with bit XLEN-1 set.
- R5: A valid exception in the same cycle as an eligible interrupt wins, and its cause is `exc_code` unchanged.
- R6: A trap goes to S only when the privilege is not M, the cause index (bit XLEN-1 cleared) is below XLEN, and the bit at that index is 1 in `int_deleg` (for interrupts) or in `exc_deleg` (for exceptions). Otherwise it goes to M.
- R7: On S entry:
  - `next_pc` = `s_vec` with its two low bits cleared;
  - `s_cause` = cause and `s_epc` = `fault_pc`;
  - `s_addr` = `exc_addr` only if `exc_has_addr`;
  - `ie[3]` takes the enable bit of the level left (`ie[0]` for U, `ie[1]` for S, `ie[2]` for M);
  - `spp` = old `priv[0]`, `ie[1]` = 0, and `priv` = S.
- R8: M entry works the same way using `m_vec`, `m_cause`, `m_epc`, `m_addr` and `ie[4]`. In addition, `mpp` takes the old 2-bit privilege, `ie[2]` = 0, and `priv` = M.
- R9: `exc_code` 3 with `dbg_attached` high raises `dbg_enter` instead of a trap, with these effects:
  - `dbg_cause` = 1 and `dbg_pc` = `fault_pc`;
  - `next_pc` = `DBG_ENTRY`;
  - privilege, `ie`, `resv_clear` and `trap_taken` are left alone.
- R10: Every trap pulses `resv_clear` and `trap_taken` for one cycle, and every write of the privilege pulses `tlb_flush`.
- R11: `mode_wr` loads `mode_in` only when it is 0, 1 or 3; code 2 is ignored. `stat_wr` loads `ie` from `stat_in`. A trap or debug entry in the same cycle overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Interrupt enable mask |
| int_deleg | input | XLEN | Interrupt delegation mask |
| exc_deleg | input | XLEN | Exception delegation mask |
| s_vec | input | XLEN | Supervisor handler address |
| m_vec | input | XLEN | Machine handler address |
| exc_valid | input | 1 | Exception request |
| exc_code | input | XLEN | Exception cause |
| exc_has_addr | input | 1 | Exception carries a bad address |
| exc_addr | input | XLEN | Bad address |
| fault_pc | input | XLEN | PC of the trapping instruction |
| dbg_attached | input | 1 | Debugger present |
| mode_wr | input | 1 | Privilege write strobe |
| mode_in | input | 2 | Privilege to write |
| stat_wr | input | 1 | Enable-bit write strobe |
| stat_in | input | 5 | {mpie, spie, mie, sie, uie} to write |
| trap_taken | output | 1 | One-cycle trap pulse |
| next_pc | output | XLEN | Redirect address |
| priv | output | 2 | Current privilege |
| ie | output | 5 | {mpie, spie, mie, sie, uie} |
| spp | output | 1 | Supervisor previous privilege |
| mpp | output | 2 | Machine previous privilege |
| s_cause | output | XLEN | Supervisor cause |
| s_epc | output | XLEN | Supervisor exception PC |
| s_addr | output | XLEN | Supervisor bad address |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine exception PC |
| m_addr | output | XLEN | Machine bad address |
| dbg_enter | output | 1 | One-cycle debug entry pulse |
| dbg_cause | output | 3 | Debug entry reason |
| dbg_pc | output | XLEN | Saved PC on debug entry |
| resv_clear | output | 1 | Load-reservation clear pulse |
| tlb_flush | output | 1 | TLB flush pulse |

## Verification
Every result of the unit is registered once. A stimulus applied before a rising edge therefore shows on all outputs right after that edge: the pulses, the redirect address, the cause registers and the privilege all appear together.

The bench drives inputs on the falling edge and removes them on the next falling edge. That second falling edge, one cycle after the stimulus, is where every check samples. Pulse strobes are checked there too, so they are seen high for exactly the cycle they belong to.

Held registers such as `m_addr` are checked after a later trap that must not touch them.

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int XLEN = 32,
  parameter int NIRQ = 16,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000,
  parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [XLEN-1:0] int_deleg,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] s_vec,
  input  logic [XLEN-1:0] m_vec,
  input  logic            exc_valid,
  input  logic [XLEN-1:0] exc_code,
  input  logic            exc_has_addr,
  input  logic [XLEN-1:0] exc_addr,
  input  logic [XLEN-1:0] fault_pc,
  input  logic            dbg_attached,
  input  logic            mode_wr,
  input  logic [1:0]      mode_in,
  input  logic            stat_wr,
  input  logic [4:0]      stat_in,
  output logic            trap_taken,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      priv,
  output logic [4:0]      ie,
  output logic            spp,
  output logic [1:0]      mpp,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_addr,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_addr,
  output logic            dbg_enter,
  output logic [2:0]      dbg_cause,
  output logic [XLEN-1:0] dbg_pc,
  output logic            resv_clear,
  output logic            tlb_flush
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int CW = $clog2(XLEN);
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic [NIRQ-1:0] cand, dl, elig;
  logic            m_ok, s_ok;
  logic [IW-1:0]   irq_idx;

  assign cand = irq_pend & irq_en;
  assign dl   = int_deleg[NIRQ-1:0];
  assign m_ok = (priv != PM) || ie[2];
  assign s_ok = (priv == PU) || (priv == PS && ie[1]);
  assign elig = (cand & ~dl & {NIRQ{m_ok}}) | (cand & dl & {NIRQ{s_ok}});

  always_comb begin
    irq_idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (elig[i]) irq_idx = IW'(i);
  end

  logic            is_dbg, take, is_int, in_range, to_s, old_ie, addr_wr;
  logic [XLEN-1:0] cause, dmask;
  logic [XLEN-2:0] cidx;

  assign is_dbg   = exc_valid && dbg_attached && exc_code == XLEN'(3);
  assign take     = (exc_valid && !is_dbg) || (!exc_valid && |elig);
  assign cause    = exc_valid ? exc_code : {1'b1, (XLEN-1)'(irq_idx)};
  assign is_int   = cause[XLEN-1];
  assign cidx     = cause[XLEN-2:0];
  assign dmask    = is_int ? int_deleg : exc_deleg;
  assign in_range = cidx < (XLEN-1)'(XLEN);
  assign to_s     = (priv != PM) && in_range && dmask[cidx[CW-1:0]];
  assign old_ie   = (priv == PM) ? ie[2] : (priv == PS) ? ie[1] : ie[0];
  assign addr_wr  = exc_valid && exc_has_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_taken <= 1'b0;
      next_pc    <= RESET_PC;
      priv       <= PM;
      ie         <= '0;
      spp        <= 1'b0;
      mpp        <= PU;
      s_cause    <= '0;
      s_epc      <= '0;
      s_addr     <= '0;
      m_cause    <= '0;
      m_epc      <= '0;
      m_addr     <= '0;
      dbg_enter  <= 1'b0;
      dbg_cause  <= '0;
      dbg_pc     <= '0;
      resv_clear <= 1'b0;
      tlb_flush  <= 1'b0;
    end else begin
      trap_taken <= 1'b0;
      dbg_enter  <= 1'b0;
      resv_clear <= 1'b0;
      tlb_flush  <= 1'b0;
      if (take) begin
        trap_taken <= 1'b1;
        resv_clear <= 1'b1;
        tlb_flush  <= 1'b1;
        if (to_s) begin
          next_pc <= {s_vec[XLEN-1:2], 2'b00};
          s_cause <= cause;
          s_epc   <= fault_pc;
          if (addr_wr) s_addr <= exc_addr;
          ie[3]   <= old_ie;
          ie[1]   <= 1'b0;
          spp     <= priv[0];
          priv    <= PS;
        end else begin
          next_pc <= {m_vec[XLEN-1:2], 2'b00};
          m_cause <= cause;
          m_epc   <= fault_pc;
          if (addr_wr) m_addr <= exc_addr;
          ie[4]   <= old_ie;
          ie[2]   <= 1'b0;
          mpp     <= priv;
          priv    <= PM;
        end
      end else if (is_dbg) begin
        dbg_enter <= 1'b1;
        dbg_cause <= 3'd1;
        dbg_pc    <= fault_pc;
        next_pc   <= DBG_ENTRY;
      end else begin
        if (mode_wr && mode_in != 2'd2) begin
          priv      <= mode_in;
          tlb_flush <= 1'b1;
        end
        if (stat_wr) ie <= stat_in;
      end
    end
  end
endmodule

module trap_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_taken,
  input logic       dbg_enter,
  input logic       resv_clear,
  input logic       tlb_flush,
  input logic [1:0] priv,
  input logic [4:0] ie
);
  p_legal_priv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    priv != 2'd2);
  p_flush_on_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (priv != $past(priv)) |-> tlb_flush);
  p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_taken, dbg_enter}));
  p_dbg_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |-> (priv == $past(priv)) && !resv_clear);
  p_m_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && priv == 2'd3) |-> !ie[2]);
  p_s_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && priv == 2'd1) |-> !ie[1] && $past(priv) != 2'd3);
  p_trap_resv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> resv_clear && tlb_flush);
endmodule

bind trap_unit trap_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trap_taken(trap_taken), .dbg_enter(dbg_enter),
  .resv_clear(resv_clear), .tlb_flush(tlb_flush), .priv(priv), .ie(ie)
);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  localparam int XLEN = 32;
  localparam int NIRQ = 16;
  localparam logic [31:0] RPC = 32'h0000_1000;
  localparam logic [31:0] DBGE = 32'h0000_0800;

  logic clk = 0, rst_n = 0;
  logic [NIRQ-1:0] irq_pend = '0, irq_en = '1;
  logic [XLEN-1:0] int_deleg = '0, exc_deleg = '0;
  logic [XLEN-1:0] s_vec = 32'h0000_3006, m_vec = 32'h0000_2003;
  logic exc_valid = 0, exc_has_addr = 0, dbg_attached = 0;
  logic [XLEN-1:0] exc_code = '0, exc_addr = '0, fault_pc = '0;
  logic mode_wr = 0, stat_wr = 0;
  logic [1:0] mode_in = '0;
  logic [4:0] stat_in = '0;
  logic trap_taken, dbg_enter, resv_clear, tlb_flush, spp;
  logic [XLEN-1:0] next_pc, s_cause, s_epc, s_addr, m_cause, m_epc, m_addr, dbg_pc;
  logic [1:0] priv, mpp;
  logic [4:0] ie;
  logic [2:0] dbg_cause;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  trap_unit #(.XLEN(XLEN), .NIRQ(NIRQ), .RESET_PC(RPC), .DBG_ENTRY(DBGE)) u_trap_unit (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .int_deleg(int_deleg), .exc_deleg(exc_deleg), .s_vec(s_vec), .m_vec(m_vec),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_has_addr(exc_has_addr),
    .exc_addr(exc_addr), .fault_pc(fault_pc), .dbg_attached(dbg_attached),
    .mode_wr(mode_wr), .mode_in(mode_in), .stat_wr(stat_wr), .stat_in(stat_in),
    .trap_taken(trap_taken), .next_pc(next_pc), .priv(priv), .ie(ie), .spp(spp),
    .mpp(mpp), .s_cause(s_cause), .s_epc(s_epc), .s_addr(s_addr),
    .m_cause(m_cause), .m_epc(m_epc), .m_addr(m_addr), .dbg_enter(dbg_enter),
    .dbg_cause(dbg_cause), .dbg_pc(dbg_pc), .resv_clear(resv_clear),
    .tlb_flush(tlb_flush)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_pend = '0; exc_valid = 0; exc_has_addr = 0; mode_wr = 0; stat_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic setup(input logic [1:0] m, input logic [4:0] e);
    @(negedge clk);
    mode_wr = 1; mode_in = m; stat_wr = 1; stat_in = e;
    step();
  endtask

  task automatic fire_irq(input logic [NIRQ-1:0] p, input logic [31:0] pc);
    @(negedge clk);
    irq_pend = p; fault_pc = pc;
    step();
  endtask

  task automatic fire_exc(input logic [31:0] code, input logic ha,
                          input logic [31:0] a, input logic [31:0] pc);
    @(negedge clk);
    exc_valid = 1; exc_code = code; exc_has_addr = ha; exc_addr = a; fault_pc = pc;
    step();
  endtask

  task automatic t_reset();
    chk("R1 priv", priv, 2'd3);
    chk("R1 pc", next_pc, RPC);
    chk("R1 ie", ie, 5'd0);
    chk("R1 pulses", {trap_taken, dbg_enter, tlb_flush, resv_clear}, 4'd0);
  endtask

  task automatic t_machine_irq();
    fire_irq(16'h0080, 32'h100);
    chk("R2 masked in M", trap_taken, 1'b0);
    setup(2'd3, 5'b00100);
    fire_irq(16'h0080, 32'h100);
    chk("R2 taken", trap_taken, 1'b1);
    chk("R4 cause", m_cause, 32'h8000_0007);
    chk("R8 epc", m_epc, 32'h100);
    chk("R8 pc", next_pc, 32'h2000);
    chk("R8 ie", ie, 5'b10000);
    chk("R8 mpp", mpp, 2'd3);
    chk("R10 pulses", {resv_clear, tlb_flush}, 2'b11);
  endtask

  task automatic t_lowest();
    setup(2'd0, 5'b00000);
    fire_irq(16'h0A08, 32'h140);
    chk("R2 below M", trap_taken, 1'b1);
    chk("R4 lowest", m_cause, 32'h8000_0003);
    chk("R8 mpp from U", mpp, 2'd0);
    chk("R8 priv", priv, 2'd3);
  endtask

  task automatic t_deleg_irq();
    int_deleg = 32'h20;
    setup(2'd1, 5'b00000);
    fire_irq(16'h0020, 32'h200);
    chk("R3 S no sie", trap_taken, 1'b0);
    setup(2'd1, 5'b00010);
    fire_irq(16'h0020, 32'h200);
    chk("R3 S with sie", trap_taken, 1'b1);
    chk("R6 to S", priv, 2'd1);
    chk("R7 cause", s_cause, 32'h8000_0005);
    chk("R7 epc", s_epc, 32'h200);
    chk("R7 pc", next_pc, 32'h3004);
    chk("R7 spp", spp, 1'b1);
    chk("R7 ie", ie, 5'b01000);
    setup(2'd3, 5'b00110);
    fire_irq(16'h0020, 32'h200);
    chk("R3 never in M", trap_taken, 1'b0);
    int_deleg = '0;
  endtask

  task automatic t_priority();
    setup(2'd0, 5'b00000);
    @(negedge clk);
    irq_pend = 16'h0004; exc_valid = 1; exc_code = 32'd13;
    exc_has_addr = 1; exc_addr = 32'hDEAD_0000; fault_pc = 32'h300;
    step();
    chk("R5 exc wins", m_cause, 32'd13);
    chk("R8 addr", m_addr, 32'hDEAD_0000);
    chk("R8 epc", m_epc, 32'h300);
    setup(2'd0, 5'b00000);
    fire_exc(32'd2, 1'b0, 32'h1111, 32'h310);
    chk("R8 cause", m_cause, 32'd2);
    chk("R8 addr kept", m_addr, 32'hDEAD_0000);
  endtask

  task automatic t_deleg_exc();
    exc_deleg = 32'h100;
    setup(2'd0, 5'b00000);
    fire_exc(32'd8, 1'b1, 32'h44, 32'h400);
    chk("R6 U to S", priv, 2'd1);
    chk("R7 cause", s_cause, 32'd8);
    chk("R7 addr", s_addr, 32'h44);
    chk("R7 spp U", spp, 1'b0);
    fire_exc(32'd8, 1'b0, 32'h99, 32'h410);
    chk("R6 S to S", priv, 2'd1);
    chk("R7 spp S", spp, 1'b1);
    chk("R7 addr kept", s_addr, 32'h44);
    setup(2'd3, 5'b00000);
    fire_exc(32'd8, 1'b0, 32'h0, 32'h420);
    chk("R6 M stays M", {priv, m_cause}, {2'd3, 32'd8});
    exc_deleg = '1;
    setup(2'd1, 5'b00000);
    fire_exc(32'd40, 1'b0, 32'h0, 32'h430);
    chk("R6 index range", {priv, m_cause}, {2'd3, 32'd40});
    exc_deleg = '0;
  endtask

  task automatic t_debug();
    setup(2'd1, 5'b00010);
    dbg_attached = 1;
    fire_exc(32'd3, 1'b0, 32'h0, 32'h500);
    chk("R9 enter", {dbg_enter, trap_taken, resv_clear, tlb_flush}, 4'b1000);
    chk("R9 cause", dbg_cause, 3'd1);
    chk("R9 dpc", dbg_pc, 32'h500);
    chk("R9 pc", next_pc, DBGE);
    chk("R9 state", {priv, ie}, {2'd1, 5'b00010});
    dbg_attached = 0;
    fire_exc(32'd3, 1'b0, 32'h0, 32'h510);
    chk("R9 no debugger", {trap_taken, m_cause}, {1'b1, 32'd3});
  endtask

  task automatic t_mode();
    setup(2'd1, 5'b00000);
    chk("R10 flush on write", {tlb_flush, priv}, {1'b1, 2'd1});
    @(negedge clk);
    mode_wr = 1; mode_in = 2'd2;
    step();
    chk("R11 code 2 ignored", {tlb_flush, priv}, {1'b0, 2'd1});
    @(negedge clk);
    mode_wr = 1; mode_in = 2'd0; stat_wr = 1; stat_in = 5'b00001;
    exc_valid = 1; exc_code = 32'd2; fault_pc = 32'h600;
    step();
    chk("R11 trap wins", {priv, m_cause, ie}, {2'd3, 32'd2, 5'b00000});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_machine_irq();
    t_lowest();
    t_deleg_irq();
    t_priority();
    t_deleg_exc();
    t_debug();
    t_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule